// File: doc/BRIEF.md
# Scoreboard Instruction Issue Controller

This block sits between an in-order decode stage and a pool of unpipelined functional units. It takes one decoded instruction at a time, carrying a unit kind, a destination register and two source registers from an eight-entry register file. It then decides three things. The first is when the instruction may be handed to a unit. The second is when that unit may collect its operands. The third is when the unit may put its result back into the register file. Instructions enter the units strictly in program order, but they may finish out of order.

Each unit keeps a status entry: whether it is occupied, its destination, its two sources, the unit expected to produce each source, and whether each source is available yet. A per-register table records which unit will write each register, and that table is also what the block shows as its pending-write vector. Write-after-write conflicts stop dispatch, because the block does no renaming. Write-after-read conflicts are resolved by leaving a finished result inside its unit until every earlier reader of the old value has collected it. The unit datapaths are outside the block. Each unit reports only a level that says its result is ready.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset no register is pending and no operand-read or writeback strobe is active. The first valid instruction is accepted in the same cycle it is presented.
- R2: An accepted instruction goes to the lowest-numbered idle unit of the requested kind, and `issue_unit` reports that number. Kind codes are 0 add, 1 multiply and 2 divide. With the default parameters, units 0 and 1 multiply, unit 2 adds and unit 3 divides.
- R3: While every unit of the requested kind is occupied, `issue_ok` stays low.
- R4: While the destination register has a pending writer, `issue_ok` stays low. This holds even in the cycle that writer performs its writeback.
- R5: Bit r of `reg_pending` (register r) rises in the cycle after an instruction writing r is accepted. It falls in the cycle after that writeback.
- R6: A unit raises its operand-read strobe in the cycle after acceptance when neither source has a pending writer. Otherwise it raises the strobe in the cycle after the last producer of its sources writes back.
- R7: When a source's producer writes back in the same cycle a consumer is accepted, that source counts as available, and the consumer reads its operands in the next cycle.
- R8: Each accepted instruction produces exactly one operand-read strobe.
- R9: A unit whose result is ready and whose operands have been read raises its writeback strobe in that cycle. The exception is when an earlier unit has an available but unread source equal to its destination; then the writeback waits until the cycle after that read.
- R10: A writeback frees the unit, so a new instruction can be accepted by it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_kind | input | KIND_W | Unit kind the instruction needs |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| issue_ok | output | 1 | The presented instruction is accepted this cycle |
| issue_unit | output | UID_W | Unit receiving the accepted instruction |
| fu_done | input | NUM_FU | Per unit: result is ready, held until writeback |
| fu_go_read | output | NUM_FU | Per unit: read operands this cycle |
| fu_go_write | output | NUM_FU | Per unit: write result back this cycle |
| reg_pending | output | 2**REG_W | Per register: a write is outstanding |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is dispatch and writeback. The bench accepts a consumer in the exact cycle its producer writes back, and requires the consumer's operand read one cycle later. It also presents a write-after-write instruction while the old writer retires, and requires a stall. The second pair is one unit's operand read and another unit's writeback of the register being read. Here the bench holds a finished multiplier behind a waiting adder and requires the multiplier's writeback only in the cycle after the adder's read. Every strobe is compared against expected cycles that the driver queues from the requirements.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int REG_W = 3;
  localparam int KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    FU_ADD = 2'd0,
    FU_MUL = 2'd1,
    FU_DIV = 2'd2
  } fu_kind_e;
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
  parameter int NUM_FU = 4,
  parameter int KIND_W = 2,
  parameter int UID_W  = $clog2(NUM_FU),
  parameter logic [NUM_FU*KIND_W-1:0] FU_KIND = 8'b10_00_01_01
) (
  input  logic [NUM_FU-1:0] busy,
  input  logic [KIND_W-1:0] kind,
  output logic              free_any,
  output logic [UID_W-1:0]  sel
);
  always_comb begin
    free_any = 1'b0;
    sel = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (!busy[i] && FU_KIND[i*KIND_W +: KIND_W] == kind) begin
        free_any = 1'b1;
        sel = UID_W'(i);
      end
    end
  end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_FU = 4,
  parameter int REG_W  = 3,
  parameter int UID_W  = $clog2(NUM_FU),
  localparam int NREG  = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_en,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [UID_W-1:0]  issue_uid,
  input  logic [REG_W-1:0]  look_a,
  input  logic [REG_W-1:0]  look_b,
  input  logic [NUM_FU-1:0] wr_vec,
  input  logic [REG_W-1:0]  wr_dst [NUM_FU],
  output logic              a_busy,
  output logic [UID_W-1:0]  a_uid,
  output logic              b_busy,
  output logic [UID_W-1:0]  b_uid,
  output logic              dst_busy,
  output logic [NREG-1:0]   pending
);
  logic [UID_W-1:0] owner [NREG];

  assign a_busy   = pending[look_a];
  assign a_uid    = owner[look_a];
  assign b_busy   = pending[look_b];
  assign b_uid    = owner[look_b];
  assign dst_busy = pending[issue_dst];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++)
        if (wr_vec[u]) pending[wr_dst[u]] <= 1'b0;
      if (issue_en) pending[issue_dst] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_en) owner[issue_dst] <= issue_uid;
  end

  // R4: a new writer is never recorded over an outstanding one
  assert_no_waw_R4: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> !pending[issue_dst]);

  for (genvar u = 0; u < NUM_FU; u++) begin : g_own
    // R5: the unit writing back is the recorded writer of its destination
    assert_owner_R5: assert property (@(posedge clk) disable iff (rst)
      wr_vec[u] |-> (pending[wr_dst[u]] && owner[wr_dst[u]] == UID_W'(u)));
  end
endmodule

// File: rtl/sb_unit.sv
module sb_unit #(
  parameter int NUM_FU = 4,
  parameter int REG_W  = 3,
  parameter int UID_W  = $clog2(NUM_FU),
  localparam int NREG  = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_en,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src_a,
  input  logic [REG_W-1:0]  in_src_b,
  input  logic [UID_W-1:0]  prod_a,
  input  logic [UID_W-1:0]  prod_b,
  input  logic              rdy_a,
  input  logic              rdy_b,
  input  logic [NUM_FU-1:0] wb_vec,
  input  logic              done,
  input  logic              war_block,
  output logic              busy,
  output logic [REG_W-1:0]  dst_o,
  output logic [NREG-1:0]   claim,
  output logic              go_read,
  output logic              go_write
);
  logic             rd_done;
  logic [REG_W-1:0] src_a_q, src_b_q;
  logic [UID_W-1:0] prod_a_q, prod_b_q;
  logic             rdy_a_q, rdy_b_q;

  assign go_read  = busy && !rd_done && rdy_a_q && rdy_b_q;
  assign go_write = busy && rd_done && done && !war_block;

  always_comb begin
    for (int r = 0; r < NREG; r++)
      claim[r] = busy && !rd_done &&
                 ((rdy_a_q && src_a_q == REG_W'(r)) || (rdy_b_q && src_b_q == REG_W'(r)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_done <= 1'b0;
      rdy_a_q <= 1'b0;
      rdy_b_q <= 1'b0;
    end else if (issue_en) begin
      busy     <= 1'b1;
      rd_done  <= 1'b0;
      dst_o    <= in_dst;
      src_a_q  <= in_src_a;
      src_b_q  <= in_src_b;
      prod_a_q <= prod_a;
      prod_b_q <= prod_b;
      rdy_a_q  <= rdy_a;
      rdy_b_q  <= rdy_b;
    end else begin
      if (go_write) busy <= 1'b0;
      if (go_read) rd_done <= 1'b1;
      if (busy && !rdy_a_q && wb_vec[prod_a_q]) rdy_a_q <= 1'b1;
      if (busy && !rdy_b_q && wb_vec[prod_b_q]) rdy_b_q <= 1'b1;
    end
  end

  // R3: dispatch only ever targets an idle unit
  assert_idle_on_issue_R3: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> !busy);
  // R8: one operand read per instruction
  assert_read_once_R8: assert property (@(posedge clk) disable iff (rst)
    go_read |=> !go_read);
endmodule

// File: rtl/scoreboard_issue.sv
module scoreboard_issue
  import sb_pkg::*;
#(
  parameter int NUM_FU = 4,
  parameter logic [NUM_FU*KIND_W-1:0] FU_KIND = 8'b10_00_01_01,
  localparam int UID_W = $clog2(NUM_FU),
  localparam int NREG  = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  output logic              issue_ok,
  output logic [UID_W-1:0]  issue_unit,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] fu_go_read,
  output logic [NUM_FU-1:0] fu_go_write,
  output logic [NREG-1:0]   reg_pending
);
  logic [NUM_FU-1:0] busy, issue_vec, war_blk;
  logic [REG_W-1:0]  dst_u [NUM_FU];
  logic [NREG-1:0]   claim_u [NUM_FU];
  logic [NREG-1:0]   claim_all;
  logic              free_any, dst_busy, a_busy, b_busy, rdy_a, rdy_b;
  logic [UID_W-1:0]  a_uid, b_uid;

  sb_issue_sel #(.NUM_FU(NUM_FU), .KIND_W(KIND_W), .FU_KIND(FU_KIND)) i_sel (
    .busy(busy), .kind(in_kind), .free_any(free_any), .sel(issue_unit));

  sb_reg_status #(.NUM_FU(NUM_FU), .REG_W(REG_W)) i_regs (
    .clk(clk), .rst(rst), .issue_en(issue_ok), .issue_dst(in_dst),
    .issue_uid(issue_unit), .look_a(in_src1), .look_b(in_src2),
    .wr_vec(fu_go_write), .wr_dst(dst_u), .a_busy(a_busy), .a_uid(a_uid),
    .b_busy(b_busy), .b_uid(b_uid), .dst_busy(dst_busy), .pending(reg_pending));

  assign issue_ok = in_valid && free_any && !dst_busy;
  assign rdy_a = !a_busy || fu_go_write[a_uid];
  assign rdy_b = !b_busy || fu_go_write[b_uid];

  always_comb begin
    claim_all = '0;
    for (int u = 0; u < NUM_FU; u++) claim_all |= claim_u[u];
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    assign issue_vec[u] = issue_ok && issue_unit == UID_W'(u);
    assign war_blk[u]   = claim_all[dst_u[u]];
    sb_unit #(.NUM_FU(NUM_FU), .REG_W(REG_W)) i_unit (
      .clk(clk), .rst(rst), .issue_en(issue_vec[u]), .in_dst(in_dst),
      .in_src_a(in_src1), .in_src_b(in_src2), .prod_a(a_uid), .prod_b(b_uid),
      .rdy_a(rdy_a), .rdy_b(rdy_b), .wb_vec(fu_go_write), .done(fu_done[u]),
      .war_block(war_blk[u]), .busy(busy[u]), .dst_o(dst_u[u]),
      .claim(claim_u[u]), .go_read(fu_go_read[u]), .go_write(fu_go_write[u]));
  end

  // R2: at most one unit receives an instruction per cycle
  assert_single_issue_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_vec));
  // R10: a unit that wrote back is idle in the next cycle
  assert_free_after_write_R10: assert property (@(posedge clk) disable iff (rst)
    (fu_go_write != '0) |=> ((busy & $past(fu_go_write)) == '0) || $past(issue_ok));
endmodule

// File: tb/test_scoreboard_issue.sv
module test_scoreboard_issue;
  localparam logic [1:0] K_ADD = 2'd0, K_MUL = 2'd1, K_DIV = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic issue_ok;
  logic [1:0] issue_unit;
  logic [3:0] fu_done = '0, fu_go_read, fu_go_write;
  logic [7:0] reg_pending;

  scoreboard_issue i_scoreboard_issue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_ok(issue_ok), .issue_unit(issue_unit), .fu_done(fu_done),
    .fu_go_read(fu_go_read), .fu_go_write(fu_go_write),
    .reg_pending(reg_pending));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; bit wr; int unit; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, failures = 0;
  bit finished = 0;
  logic [3:0] wr_seen = '0;

  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(bit wr, int u, int c);
    exp_t e;
    e.cyc = c; e.wr = wr; e.unit = u;
    q.push_back(e);
  endtask

  task automatic match_ev(bit wr, int u);
    int idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].wr == wr && q[i].unit == u) idx = i;
    checks++;
    if (idx < 0) begin
      failures++;
      $display("FAIL R8 unexpected %s strobe unit %0d actual=cycle %0d expected=none",
               wr ? "write" : "read", u, cyc);
    end else begin
      if (q[idx].cyc != cyc) begin
        failures++;
        $display("FAIL %s %s strobe unit %0d actual=%0d expected=%0d",
                 wr ? "R9" : "R6", wr ? "write" : "read", u, cyc, q[idx].cyc);
      end
      q.delete(idx);
    end
  endtask

  // monitor: observe strobes between edges, pop and compare
  initial forever begin
    @(negedge clk);
    #1;
    if (!rst) begin
      for (int u = 0; u < 4; u++) if (fu_go_read[u]) match_ev(1'b0, u);
      for (int u = 0; u < 4; u++) if (fu_go_write[u]) match_ev(1'b1, u);
    end
    wr_seen = fu_go_write;
  end

  task automatic tick();
    @(negedge clk);
    in_valid = 1'b0;
    fu_done = fu_done & ~wr_seen;
  endtask

  task automatic issue(logic [1:0] k, logic [2:0] d, logic [2:0] a, logic [2:0] b);
    in_valid = 1'b1; in_kind = k; in_dst = d; in_src1 = a; in_src2 = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    tick(); #1;
    chk("R1 reg_pending", reg_pending, 0);
    chk("R1 go_read", fu_go_read, 0);
    chk("R1 go_write", fu_go_write, 0);
    // single add
    tick(); issue(K_ADD, 1, 2, 3); #1;
    chk("R1 issue_ok", issue_ok, 1);
    chk("R2 unit", issue_unit, 2);
    expect_ev(0, 2, cyc + 1);
    tick(); #1; chk("R5 pending set", reg_pending, 8'h02);
    tick(); fu_done[2] = 1'b1; expect_ev(1, 2, cyc); #1;
    chk("R9 write", fu_go_write, 4'b0100);
    tick(); #1; chk("R5 pending clear", reg_pending, 0);

    // RAW, structural stall, lowest index, reuse
    tick(); issue(K_MUL, 4, 1, 1); #1; chk("R2 unit", issue_unit, 0);
    expect_ev(0, 0, cyc + 1);
    tick(); issue(K_MUL, 5, 4, 2); #1; chk("R2 issue_ok", issue_ok, 1);
    chk("R2 unit", issue_unit, 1);
    tick(); issue(K_MUL, 6, 0, 0); #1; chk("R3 stall", issue_ok, 0);
    tick(); fu_done[0] = 1'b1; expect_ev(1, 0, cyc); expect_ev(0, 1, cyc + 1);
    tick(); issue(K_MUL, 6, 0, 0); #1;
    chk("R10 reuse ok", issue_ok, 1); chk("R10 reuse unit", issue_unit, 0);
    chk("R5 pending", reg_pending, 8'h20);
    expect_ev(0, 0, cyc + 1);
    tick();
    tick(); fu_done[0] = 1'b1; fu_done[1] = 1'b1;
    expect_ev(1, 0, cyc); expect_ev(1, 1, cyc);
    tick(); #1; chk("R5 pending clear", reg_pending, 0);

    // WAW stall, including in the writer's writeback cycle
    tick(); issue(K_DIV, 3, 0, 0); #1; chk("R2 unit", issue_unit, 3);
    expect_ev(0, 3, cyc + 1);
    tick(); issue(K_ADD, 3, 1, 1); #1; chk("R4 stall", issue_ok, 0);
    tick(); fu_done[3] = 1'b1; issue(K_ADD, 3, 1, 1); #1;
    chk("R4 stall at writeback", issue_ok, 0); expect_ev(1, 3, cyc);
    tick(); issue(K_ADD, 3, 1, 1); #1; chk("R4 release", issue_ok, 1);
    chk("R2 unit", issue_unit, 2); expect_ev(0, 2, cyc + 1);
    tick(); tick(); fu_done[2] = 1'b1; expect_ev(1, 2, cyc);
    tick();

    // same-cycle writeback and dispatch of a consumer
    tick(); issue(K_DIV, 2, 0, 0); expect_ev(0, 3, cyc + 1);
    tick();
    tick(); fu_done[3] = 1'b1; issue(K_ADD, 7, 2, 1); #1;
    chk("R7 issue_ok", issue_ok, 1);
    expect_ev(1, 3, cyc); expect_ev(0, 2, cyc + 1);
    tick(); tick(); fu_done[2] = 1'b1; expect_ev(1, 2, cyc);
    tick();

    // WAR: finished result held until the earlier reader collects
    tick(); issue(K_DIV, 1, 0, 0); expect_ev(0, 3, cyc + 1);
    tick(); issue(K_ADD, 6, 1, 5); #1; chk("R2 unit", issue_unit, 2);
    tick(); issue(K_MUL, 5, 0, 0); #1; chk("R2 unit", issue_unit, 0);
    expect_ev(0, 0, cyc + 1);
    tick();
    tick(); fu_done[0] = 1'b1; #1; chk("R9 held", fu_go_write[0], 0);
    tick(); fu_done[3] = 1'b1; expect_ev(1, 3, cyc); expect_ev(0, 2, cyc + 1); #1;
    chk("R9 held", fu_go_write[0], 0);
    tick(); #1; chk("R9 held during read", fu_go_write[0], 0);
    expect_ev(1, 0, cyc + 1);
    tick(); #1; chk("R9 released", fu_go_write[0], 1);
    tick(); fu_done[2] = 1'b1; expect_ev(1, 2, cyc);

    repeat (5) tick();
    #1;
    chk("R8 all strobes seen", q.size(), 0);
    for (int i = 0; i < q.size(); i++)
      $display("FAIL R6 missing %s strobe unit %0d actual=none expected=%0d",
               q[i].wr ? "write" : "read", q[i].unit, q[i].cyc);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule